// File: doc/BRIEF.md
# Strobed Serial Control Word Receiver

This block sits on the device side of a three-wire control link made of a serial clock, a data line and a strobe, plus an asynchronous active-low reset. A host raises the strobe and clocks in a 14-bit control word, most significant bit first. When the strobe falls, the receiver copies the word into one of four function registers. The two top bits of the word pick the register: mode control, input volume, equalizer volume or bias level. The register contents come out as parallel codes that drive the analog stages of a tape signal path. Those stages are not part of this block.

Two interlocks tie the registers together. A mode write that changes the tape type wipes the bias level to its muted all-zeros code. While the input selector points at the record/playback input, the input-volume output shows its mute code, whatever value is stored. The three serial pins pass through two-flop synchronizers into the system clock domain. All edges are detected from the synchronized samples, so the serial clock must stay well below the system clock.

Top module: `ctl_word_rx`

## Requirements
- R1: While `rst_n` is low, every output is zero at once, without waiting for a clock edge.
- R2: Serial clock rising edges that arrive while the strobe is low do not change the shift contents. A later strobe with no clock pulses therefore re-delivers the previous word unchanged.
- R3: While the strobe is high, each serial clock rising edge shifts `ser_dat` into bit 0 and moves the older bits up by one. On the strobe's falling edge the 14-bit shift contents go to a register. A word cut short is delivered as-is, with the older bits still in the upper positions. Registers change only on a strobe fall.
- R4: Word bits {13,12} pick the target register: 00 mode, 01 input volume, 10 equalizer volume, 11 bias.
- R5: The mode word maps bits as follows:
  - [1:0] go to `tape_sel`: 00 or 01 normal, 10 chrome, 11 metal.
  - bit 2 goes to `fast_speed`.
  - bit 3 goes to `meter_boost`.
  - [5:4] go to `src_sel`: 00 first line, 01 record/playback input, 10 second line, 11 third line.
  - bit 6 goes to `pb_mode` (1 = playback).
  - bit 7 goes to `gain_set`.
  - bit 8 goes to `mpx_en`.
  - bit 9 goes to `nr_en`.
  - bit 10 goes to `nr_type_c` (0 = B, 1 = C).
- R6: A volume or bias word carries its code in the low bits: input volume in [5:0], equalizer volume in [4:0], bias in [5:0]. All-ones means mute for the two volumes, and all-zeros means mute for bias. Such a write changes no other register.
- R7: A mode write whose bits [1:0] differ from the stored tape type clears the bias code to 0. A mode write that keeps the same tape type leaves the bias code alone.
- R8: While `src_sel` is 01, `in_vol` reads 6'h3F. The stored input-volume code comes back once another input is selected.
- R9: Pulling `rst_n` low in the middle of operation clears all registers. Operation resumes normally after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_stb | input | 1 | Strobe; high frames a word, its fall delivers it |
| tape_sel | output | 2 | Tape type code |
| fast_speed | output | 1 | High transport speed |
| meter_boost | output | 1 | Meter range raised by 20 dB |
| src_sel | output | 2 | Input selector |
| pb_mode | output | 1 | 1 = playback, 0 = record |
| gain_set | output | 1 | Volume gain set select |
| mpx_en | output | 1 | Multiplex filter enable |
| nr_en | output | 1 | Noise reduction enable |
| nr_type_c | output | 1 | Noise reduction type, 1 = C |
| in_vol | output | 6 | Input volume code, mute-forced on the record/playback input |
| eq_vol | output | 5 | Equalizer volume code |
| bias_code | output | 6 | Bias level code, 0 = muted |

## Verification
The bench checks the bias interlock in both directions: a design that cleared bias on every mode write, or only on some tape changes, shows a wrong `bias_code` right after the mode word. It checks that the record/playback input masks the stored input volume and then gives it back: a design that overwrote the register would not return the old code. It sends short words and stray clock pulses outside the strobe window. A design that reset its shifter at strobe rise, or shifted while the strobe was low, would deliver a different word or target. Each random word is compared field by field, so a design that routed a word to the wrong register, or swapped any field position, is caught.

// File: rtl/ctl_word_rx.sv
module ctl_word_rx #(
  parameter int WORD_W = 14,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_dat,
  input  logic       ser_stb,
  output logic [1:0] tape_sel,
  output logic       fast_speed,
  output logic       meter_boost,
  output logic [1:0] src_sel,
  output logic       pb_mode,
  output logic       gain_set,
  output logic       mpx_en,
  output logic       nr_en,
  output logic       nr_type_c,
  output logic [5:0] in_vol,
  output logic [4:0] eq_vol,
  output logic [5:0] bias_code
);
  localparam int PIPE = SYNC_N + 1;
  localparam logic [1:0] SRC_RP = 2'b01;

  logic [PIPE-1:0]   ck_q, dt_q, st_q;
  logic [WORD_W-1:0] sh;
  logic [10:0]       mode_r;
  logic [5:0]        ivol_r, bias_r;
  logic [4:0]        evol_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0;
      dt_q <= '0;
      st_q <= '0;
    end else begin
      ck_q <= {ck_q[PIPE-2:0], ser_clk};
      dt_q <= {dt_q[PIPE-2:0], ser_dat};
      st_q <= {st_q[PIPE-2:0], ser_stb};
    end

  wire stb_hi   = st_q[SYNC_N-1];
  wire ck_rise  = ck_q[SYNC_N-1] & ~ck_q[SYNC_N];
  wire stb_fall = st_q[SYNC_N] & ~st_q[SYNC_N-1];
  wire bit_in   = dt_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else if (stb_hi && ck_rise) sh <= {sh[WORD_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_r <= '0;
      ivol_r <= '0;
      evol_r <= '0;
      bias_r <= '0;
    end else if (stb_fall) begin
      unique case (sh[WORD_W-1:WORD_W-2])
        2'b00: begin
          mode_r <= sh[10:0];
          if (sh[1:0] != mode_r[1:0]) bias_r <= '0;
        end
        2'b01: ivol_r <= sh[5:0];
        2'b10: evol_r <= sh[4:0];
        default: bias_r <= sh[5:0];
      endcase
    end

  assign tape_sel    = mode_r[1:0];
  assign fast_speed  = mode_r[2];
  assign meter_boost = mode_r[3];
  assign src_sel     = mode_r[5:4];
  assign pb_mode     = mode_r[6];
  assign gain_set    = mode_r[7];
  assign mpx_en      = mode_r[8];
  assign nr_en       = mode_r[9];
  assign nr_type_c   = mode_r[10];
  assign in_vol      = (src_sel == SRC_RP) ? 6'h3F : ivol_r;
  assign eq_vol      = evol_r;
  assign bias_code   = bias_r;

  p_shift_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_hi |=> $stable(sh));

  p_write_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_fall |=> ($stable(mode_r) && $stable(ivol_r) && $stable(evol_r) && $stable(bias_r)));

  p_eq_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && sh[WORD_W-1:WORD_W-2] == 2'b10) |=> (eq_vol == $past(sh[4:0])));

  p_bias_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && sh[WORD_W-1:WORD_W-2] == 2'b00 && sh[1:0] != tape_sel) |=> (bias_code == 6'd0));

  p_rp_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_RP) |-> (in_vol == 6'h3F));
endmodule

// File: tb/test_ctl_word_rx.sv
module test_ctl_word_rx;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_stb = 0;
  logic [1:0] tape_sel, src_sel;
  logic fast_speed, meter_boost, pb_mode, gain_set, mpx_en, nr_en, nr_type_c;
  logic [5:0] in_vol, bias_code;
  logic [4:0] eq_vol;

  ctl_word_rx i_ctl_word_rx (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [13:0] m_sh = 0;
  logic [10:0] m_mode = 0;
  logic [5:0]  m_iv = 0, m_bias = 0;
  logic [4:0]  m_ev = 0;

  function automatic logic [13:0] mk(input logic [1:0] sel, input logic [11:0] pl);
    return {sel, pl};
  endfunction

  function automatic logic [5:0] exp_in_vol();
    return (m_mode[5:4] == 2'b01) ? 6'h3F : m_iv;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "tape_sel",    tape_sel,    m_mode[1:0]);
    chk(req, "fast_speed",  fast_speed,  m_mode[2]);
    chk(req, "meter_boost", meter_boost, m_mode[3]);
    chk(req, "src_sel",     src_sel,     m_mode[5:4]);
    chk(req, "pb_mode",     pb_mode,     m_mode[6]);
    chk(req, "gain_set",    gain_set,    m_mode[7]);
    chk(req, "mpx_en",      mpx_en,      m_mode[8]);
    chk(req, "nr_en",       nr_en,       m_mode[9]);
    chk(req, "nr_type_c",   nr_type_c,   m_mode[10]);
    chk(req, "in_vol",      in_vol,      exp_in_vol());
    chk(req, "eq_vol",      eq_vol,      m_ev);
    chk(req, "bias_code",   bias_code,   m_bias);
  endtask

  task automatic model_fall();
    case (m_sh[13:12])
      2'b00: begin
        if (m_sh[1:0] != m_mode[1:0]) m_bias = 0;
        m_mode = m_sh[10:0];
      end
      2'b01: m_iv = m_sh[5:0];
      2'b10: m_ev = m_sh[4:0];
      default: m_bias = m_sh[5:0];
    endcase
  endtask

  task automatic pulse(input logic b);
    ser_dat = b;
    repeat (4) @(posedge clk);
    ser_clk = 1;
    repeat (4) @(posedge clk);
    ser_clk = 0;
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) pulse(1'b1);
    repeat (4) @(posedge clk);
  endtask

  task automatic send(input logic [13:0] w, input int n, input string req);
    ser_stb = 1;
    repeat (4) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      pulse(w[13-i]);
      m_sh = {m_sh[12:0], w[13-i]};
    end
    repeat (4) @(posedge clk);
    ser_stb = 0;
    repeat (6) @(posedge clk);
    model_fall();
    @(negedge clk);
    chk_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h1A2B);
    #12;
    chk_all("R1");
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);

    send(mk(2'b00, 12'h75D), 14, "R5");
    send(mk(2'b00, 12'h2A2), 14, "R5");
    send(mk(2'b01, 12'h02A), 14, "R6");
    send(mk(2'b10, 12'h013), 14, "R4");
    send(mk(2'b11, 12'h02A), 14, "R6");
    send(mk(2'b10, 12'h01F), 14, "R6");
    send(mk(2'b01, 12'h03F), 14, "R6");
    send(mk(2'b01, 12'h012), 14, "R6");
    send(mk(2'b00, 12'h003), 14, "R7");
    send(mk(2'b11, 12'h015), 14, "R7");
    send(mk(2'b00, 12'h3C3), 14, "R7");
    send(mk(2'b00, 12'h013), 14, "R8");
    send(mk(2'b00, 12'h023), 14, "R8");
    send(mk(2'b00, 12'h0B2), 14, "R2");
    stray(5);
    send(14'h0000, 0, "R2");
    send(mk(2'b01, 12'h0F8), 6, "R3");
    send(mk(2'b00, 12'h001), 3, "R3");

    for (int k = 0; k < 300; k++) begin
      logic [13:0] w;
      int n;
      w = 14'($urandom);
      n = ($urandom % 8 == 0) ? int'($urandom % 14) : 14;
      if ($urandom % 10 == 0) stray(int'($urandom % 3) + 1);
      send(w, n, (n == 14) ? "R4" : "R3");
    end

    send(mk(2'b11, 12'h03A), 14, "R9");
    send(mk(2'b00, 12'h355), 14, "R9");
    @(negedge clk);
    rst_n = 0;
    #2;
    m_sh = 0; m_mode = 0; m_iv = 0; m_ev = 0; m_bias = 0;
    chk_all("R9");
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    send(mk(2'b10, 12'h00C), 14, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule